// File: doc/BRIEF.md
# Privileged Status, Interrupt and Trap-Vector CSR Block

This block holds the machine-level status word, the interrupt pending, enable and delegation words, and the two trap-vector bases of a processor core, and it gives the supervisor-level views of them. A core pipeline drives a 12-bit CSR address with write data and a write strobe, and it may also issue a read with a read strobe in the same cycle. Each write passes through a per-register legality filter, so fields that cannot change keep their value. A translation-mode value that is not legal for the configured register width is dropped, and the summary dirty bit is always derived from the floating-point and extension state fields. It is never written.

The supervisor status, pending and enable addresses hold no storage of their own. Each one is a filtered window onto the machine word. The status window passes a fixed field subset, and the pending and enable windows pass the bits set in the delegation word. A write that changes any field that bears on address translation raises a one-cycle flush request for the translation cache. Reads are registered: the data and an illegal-address flag appear one cycle after the read strobe. The data reflects the state before any write issued in the same cycle.

Top module: `priv_csr_regs`

## Requirements
- R1: A machine status write (address 0x300) updates only SIE(1), MIE(3), SPIE(5), MPIE(7), SPP(8), MPP(12:11), FS(14:13), MPRV(17), PUM(18) and MXR(19). XS(16:15) is writable only when HAS_EXT is 1, and every other bit is left unchanged.
- R2: The translation-mode field (28:24) takes a written value only if that value is 0 (bare). With XLEN=64 the values 9 and 10 are also legal, and with XLEN=32 the value 8 is also legal. Any other value leaves the field as it was.
- R3: Bit XLEN-1 of the status value read back is 1 exactly when FS is 2'b11 or XS is 2'b11, and 0 otherwise. Writing that bit has no effect.
- R4: A pending write (0x344) changes only bit 1 (supervisor software) and bit 5 (supervisor timer). All other pending bits read back 0.
- R5: The delegation word (0x303) accepts bits 1, 5 and 9. The enable word (0x304) accepts bits 1, 3, 5, 7 and 9. All other bits read back 0.
- R6: A supervisor pending write (0x144) or enable write (0x104) changes only the machine bits that are set in the delegation word, and then only through the R4 or R5 mask. A read of either view returns the machine word ANDed with the delegation word.
- R7: The supervisor status view (0x100) reads SIE, SPIE, SPP, FS, XS and PUM, plus the summary bit at XLEN-1 computed as in R3. All other bits read 0. A write through this view changes only those six fields.
- R8: Writes to the machine trap vector (0x305) and the supervisor trap vector (0x105) store the value with bits 1:0 cleared.
- R9: tlb_flush_o is 1 for exactly the cycle after a status write (through either view) that changes the translation mode, MPP, MPRV, PUM or MXR, and 0 otherwise.
- R10: A read returns its data and illegal_o one cycle after rd_en_i, taken from the state before a same-cycle write. A read of any address other than the nine listed here sets illegal_o with rdata_o equal to 0. Writes to such addresses change no state.
- R11: After reset, all words read 0, except the machine trap vector, which reads RST_MTVEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write CSR address |
| wr_data_i | input | XLEN | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 12 | Read CSR address |
| rdata_o | output | XLEN | Read data, one cycle after rd_en_i |
| illegal_o | output | 1 | Unimplemented address read, one cycle after rd_en_i |
| tlb_flush_o | output | 1 | One-cycle translation-flush request |

## Verification
The bench writes all ones to the status word. A design that forgot the legality check would then store the illegal translation mode 31 and read back XS set. It then steps the mode through one legal and one illegal value, and toggles FS to catch a summary bit that is written instead of derived or that sits at the wrong position. Partial delegation masks go through the supervisor pending and enable views, so a design that aliased them without filtering would clear bits that belong to the machine level. The bench also writes fields that do not affect translation, such as SIE alone, where a flush would be wrong. It reads unimplemented addresses and then follows each one with a legal read, which shows a flag that sticks or data that leaks through.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_MSTAT = 12'h300;
  localparam logic [ADDR_W-1:0] A_SSTAT = 12'h100;
  localparam logic [ADDR_W-1:0] A_MIE   = 12'h304;
  localparam logic [ADDR_W-1:0] A_SIE   = 12'h104;
  localparam logic [ADDR_W-1:0] A_MIP   = 12'h344;
  localparam logic [ADDR_W-1:0] A_SIP   = 12'h144;
  localparam logic [ADDR_W-1:0] A_MDEL  = 12'h303;
  localparam logic [ADDR_W-1:0] A_MTVEC = 12'h305;
  localparam logic [ADDR_W-1:0] A_STVEC = 12'h105;

  // status field positions
  localparam int unsigned B_SIE  = 1;
  localparam int unsigned B_MIE  = 3;
  localparam int unsigned B_SPIE = 5;
  localparam int unsigned B_MPIE = 7;
  localparam int unsigned B_SPP  = 8;
  localparam int unsigned B_MPP  = 11;
  localparam int unsigned B_FS   = 13;
  localparam int unsigned B_XS   = 15;
  localparam int unsigned B_MPRV = 17;
  localparam int unsigned B_PUM  = 18;
  localparam int unsigned B_MXR  = 19;
  localparam int unsigned B_VM   = 24;
  localparam int unsigned VM_W   = 5;

  localparam logic [63:0] F_SIE  = 64'd1 << B_SIE;
  localparam logic [63:0] F_MIE  = 64'd1 << B_MIE;
  localparam logic [63:0] F_SPIE = 64'd1 << B_SPIE;
  localparam logic [63:0] F_MPIE = 64'd1 << B_MPIE;
  localparam logic [63:0] F_SPP  = 64'd1 << B_SPP;
  localparam logic [63:0] F_MPP  = 64'd3 << B_MPP;
  localparam logic [63:0] F_FS   = 64'd3 << B_FS;
  localparam logic [63:0] F_XS   = 64'd3 << B_XS;
  localparam logic [63:0] F_MPRV = 64'd1 << B_MPRV;
  localparam logic [63:0] F_PUM  = 64'd1 << B_PUM;
  localparam logic [63:0] F_MXR  = 64'd1 << B_MXR;
  localparam logic [63:0] F_VM   = 64'd31 << B_VM;

  localparam logic [63:0] STAT_BASE_WM = F_SIE | F_MIE | F_SPIE | F_MPIE | F_SPP | F_MPP
                                       | F_FS | F_MPRV | F_PUM | F_MXR;
  localparam logic [63:0] STAT_S_VIEW  = F_SIE | F_SPIE | F_SPP | F_FS | F_XS | F_PUM;
  localparam logic [63:0] STAT_FLUSH   = F_VM | F_MPP | F_MPRV | F_PUM | F_MXR;

  // interrupt bit positions
  localparam int unsigned I_SSW = 1;
  localparam int unsigned I_MSW = 3;
  localparam int unsigned I_STM = 5;
  localparam int unsigned I_MTM = 7;
  localparam int unsigned I_SEX = 9;

  localparam logic [63:0] IRQ_DELEGABLE = (64'd1 << I_SSW) | (64'd1 << I_STM) | (64'd1 << I_SEX);
  localparam logic [63:0] IRQ_EN_WM     = IRQ_DELEGABLE | (64'd1 << I_MSW) | (64'd1 << I_MTM);
  localparam logic [63:0] IRQ_PEND_WM   = (64'd1 << I_SSW) | (64'd1 << I_STM);

  // translation modes
  localparam logic [VM_W-1:0] VM_BARE = 5'd0;
  localparam logic [VM_W-1:0] VM_32   = 5'd8;
  localparam logic [VM_W-1:0] VM_39   = 5'd9;
  localparam logic [VM_W-1:0] VM_48   = 5'd10;
endpackage

// File: rtl/csr_status_unit.sv
module csr_status_unit
  import priv_csr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_EXT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_m_i,
  input  logic            wr_s_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o,
  output logic            flush_o
);
  localparam logic [XLEN-1:0] BASE_WM = STAT_BASE_WM[XLEN-1:0];
  localparam logic [XLEN-1:0] XS_WM   = HAS_EXT ? F_XS[XLEN-1:0] : '0;
  localparam logic [XLEN-1:0] VM_WM   = F_VM[XLEN-1:0];
  localparam logic [XLEN-1:0] S_WM    = STAT_S_VIEW[XLEN-1:0];
  localparam logic [XLEN-1:0] FL_M    = STAT_FLUSH[XLEN-1:0];

  logic [XLEN-1:0] stat_q, merged, stat_d;
  logic [XLEN-1:0] wmask;
  logic [VM_W-1:0] vm_new;
  logic            vm_ok;
  logic            flush_q;
  logic            any_wr;

  assign any_wr = wr_m_i | wr_s_i;
  assign vm_new = merged[B_VM +: VM_W];

  generate
    if (XLEN == 64) begin : g_vm64
      assign vm_ok = (vm_new == VM_BARE) || (vm_new == VM_39) || (vm_new == VM_48);
    end else begin : g_vm32
      assign vm_ok = (vm_new == VM_BARE) || (vm_new == VM_32);
    end
  endgenerate

  always_comb begin
    merged = wr_s_i ? ((stat_q & ~S_WM) | (wdata_i & S_WM)) : wdata_i;
    wmask  = BASE_WM | XS_WM;
    if (vm_ok) wmask = wmask | VM_WM;
    stat_d = (stat_q & ~wmask) | (merged & wmask);
    stat_d[XLEN-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= any_wr && (|((stat_d ^ stat_q) & FL_M));
      if (any_wr) stat_q <= stat_d;
    end
  end

  logic dirty;
  assign dirty = (&stat_q[B_FS +: 2]) | (&stat_q[B_XS +: 2]);

  always_comb begin
    status_o = stat_q;
    status_o[XLEN-1] = dirty;
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
  import priv_csr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_mip_i,
  input  logic            wr_sip_i,
  input  logic            wr_mie_i,
  input  logic            wr_sie_i,
  input  logic            wr_del_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] pend_o,
  output logic [XLEN-1:0] en_o,
  output logic [XLEN-1:0] deleg_o
);
  localparam logic [XLEN-1:0] PEND_WM = IRQ_PEND_WM[XLEN-1:0];
  localparam logic [XLEN-1:0] EN_WM   = IRQ_EN_WM[XLEN-1:0];
  localparam logic [XLEN-1:0] DEL_WM  = IRQ_DELEGABLE[XLEN-1:0];

  logic [XLEN-1:0] pend_q, en_q, del_q;
  logic [XLEN-1:0] pend_src, en_src;
  logic [XLEN-1:0] pend_d, en_d, del_d;

  // supervisor views narrow the write to delegated bits first
  always_comb begin
    pend_src = wr_sip_i ? ((pend_q & ~del_q) | (wdata_i & del_q)) : wdata_i;
    en_src   = wr_sie_i ? ((en_q & ~del_q) | (wdata_i & del_q)) : wdata_i;
    pend_d   = (pend_q & ~PEND_WM) | (pend_src & PEND_WM);
    en_d     = (en_q & ~EN_WM) | (en_src & EN_WM);
    del_d    = (del_q & ~DEL_WM) | (wdata_i & DEL_WM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      del_q  <= '0;
    end else begin
      if (wr_mip_i || wr_sip_i) pend_q <= pend_d;
      if (wr_mie_i || wr_sie_i) en_q <= en_d;
      if (wr_del_i) del_q <= del_d;
    end
  end

  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign deleg_o = del_q;
endmodule

// File: rtl/csr_tvec_reg.sv
module csr_tvec_reg #(
  parameter int unsigned     XLEN    = 64,
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] base_o
);
  localparam int unsigned ALIGN = 2;

  logic [XLEN-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= {RST_VAL[XLEN-1:ALIGN], {ALIGN{1'b0}}};
    else if (wr_i) base_q <= {wdata_i[XLEN-1:ALIGN], {ALIGN{1'b0}}};
  end

  assign base_o = base_q;
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import priv_csr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pend_i,
  input  logic [XLEN-1:0]   en_i,
  input  logic [XLEN-1:0]   deleg_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   stvec_i,
  output logic [XLEN-1:0]   data_o,
  output logic              hit_o
);
  localparam logic [XLEN-1:0] SD_BIT = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] S_RD   = STAT_S_VIEW[XLEN-1:0] | SD_BIT;

  always_comb begin
    data_o = '0;
    hit_o  = 1'b1;
    unique case (addr_i)
      A_MSTAT: data_o = status_i;
      A_SSTAT: data_o = status_i & S_RD;
      A_MIP:   data_o = pend_i;
      A_SIP:   data_o = pend_i & deleg_i;
      A_MIE:   data_o = en_i;
      A_SIE:   data_o = en_i & deleg_i;
      A_MDEL:  data_o = deleg_i;
      A_MTVEC: data_o = mtvec_i;
      A_STVEC: data_o = stvec_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/priv_csr_regs.sv
module priv_csr_regs
  import priv_csr_pkg::*;
#(
  parameter int unsigned     XLEN      = 64,
  parameter bit              HAS_EXT   = 1'b0,
  parameter logic [XLEN-1:0] RST_MTVEC = XLEN'(256)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [11:0]     wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            rd_en_i,
  input  logic [11:0]     rd_addr_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic            tlb_flush_o
);
  localparam int unsigned N_TVEC = 2;

  logic wr_mstat, wr_sstat, wr_mip, wr_sip, wr_mie, wr_sie, wr_del;
  logic [N_TVEC-1:0] wr_tvec;

  assign wr_mstat = wr_en_i && (wr_addr_i == A_MSTAT);
  assign wr_sstat = wr_en_i && (wr_addr_i == A_SSTAT);
  assign wr_mip   = wr_en_i && (wr_addr_i == A_MIP);
  assign wr_sip   = wr_en_i && (wr_addr_i == A_SIP);
  assign wr_mie   = wr_en_i && (wr_addr_i == A_MIE);
  assign wr_sie   = wr_en_i && (wr_addr_i == A_SIE);
  assign wr_del   = wr_en_i && (wr_addr_i == A_MDEL);
  assign wr_tvec[0] = wr_en_i && (wr_addr_i == A_MTVEC);
  assign wr_tvec[1] = wr_en_i && (wr_addr_i == A_STVEC);

  logic [XLEN-1:0] status_w, pend_w, en_w, del_w;
  logic [XLEN-1:0] tvec_w [N_TVEC];
  logic [XLEN-1:0] mux_data;
  logic            mux_hit;

  csr_status_unit #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_m_i   (wr_mstat),
    .wr_s_i   (wr_sstat),
    .wdata_i  (wr_data_i),
    .status_o (status_w),
    .flush_o  (tlb_flush_o)
  );

  csr_irq_unit #(.XLEN(XLEN)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_mip_i (wr_mip),
    .wr_sip_i (wr_sip),
    .wr_mie_i (wr_mie),
    .wr_sie_i (wr_sie),
    .wr_del_i (wr_del),
    .wdata_i  (wr_data_i),
    .pend_o   (pend_w),
    .en_o     (en_w),
    .deleg_o  (del_w)
  );

  generate
    for (genvar gi = 0; gi < N_TVEC; gi++) begin : g_tvec
      csr_tvec_reg #(
        .XLEN    (XLEN),
        .RST_VAL (gi == 0 ? RST_MTVEC : '0)
      ) u_tvec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_tvec[gi]),
        .wdata_i (wr_data_i),
        .base_o  (tvec_w[gi])
      );
    end
  endgenerate

  csr_read_mux #(.XLEN(XLEN)) u_rmux (
    .addr_i   (rd_addr_i),
    .status_i (status_w),
    .pend_i   (pend_w),
    .en_i     (en_w),
    .deleg_i  (del_w),
    .mtvec_i  (tvec_w[0]),
    .stvec_i  (tvec_w[1]),
    .data_o   (mux_data),
    .hit_o    (mux_hit)
  );

  logic [XLEN-1:0] rdata_q;
  logic            illegal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= rd_en_i && !mux_hit;
      if (rd_en_i) rdata_q <= mux_hit ? mux_data : '0;
    end
  end

  assign rdata_o   = rdata_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/priv_csr_regs_chk.sv
module priv_csr_regs_chk
  import priv_csr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_EXT = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [XLEN-1:0] rdata_o,
  input logic            illegal_o,
  input logic            tlb_flush_o,
  input logic [XLEN-1:0] status_w,
  input logic [XLEN-1:0] pend_w,
  input logic [XLEN-1:0] en_w,
  input logic [XLEN-1:0] del_w,
  input logic [XLEN-1:0] mtvec_w,
  input logic [XLEN-1:0] stvec_w
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else live_q <= 1'b1;
  end

  logic [VM_W-1:0] vm_now;
  logic            vm_ok;
  assign vm_now = status_w[B_VM +: VM_W];
  assign vm_ok  = (vm_now == VM_BARE) ||
                  ((XLEN == 64) && (vm_now == VM_39 || vm_now == VM_48)) ||
                  ((XLEN == 32) && (vm_now == VM_32));

  assert_xs_locked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_EXT |-> (status_w[B_XS +: 2] == 2'b00));

  assert_vm_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni) vm_ok);

  assert_pend_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & ~IRQ_PEND_WM[XLEN-1:0]) == '0);

  assert_deleg_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_w & ~IRQ_DELEGABLE[XLEN-1:0]) == '0);

  assert_en_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w & ~IRQ_EN_WM[XLEN-1:0]) == '0);

  assert_tvec_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtvec_w[1:0] == 2'b00) && (stvec_w[1:0] == 2'b00));

  assert_flush_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && tlb_flush_o) |-> $past(wr_en_i));

  assert_illegal_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && illegal_o) |-> $past(rd_en_i));

  assert_illegal_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (rdata_o == '0));
endmodule

bind priv_csr_regs priv_csr_regs_chk #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .illegal_o   (illegal_o),
  .tlb_flush_o (tlb_flush_o),
  .status_w    (status_w),
  .pend_w      (pend_w),
  .en_w        (en_w),
  .del_w       (del_w),
  .mtvec_w     (tvec_w[0]),
  .stvec_w     (tvec_w[1])
);

// File: tb/priv_csr_regs_tb.sv
`timescale 1ns/1ps
module priv_csr_regs_tb;
  localparam int XLEN = 64;
  localparam logic [63:0] RSTV = 64'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rdata;
  logic        illegal, flush;

  always #2.5 clk = ~clk;

  priv_csr_regs #(.XLEN(XLEN), .HAS_EXT(1'b0), .RST_MTVEC(RSTV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rdata_o(rdata), .illegal_o(illegal), .tlb_flush_o(flush)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [63:0] m_st = '0, m_ip = '0, m_ie = '0, m_dl = '0, m_mt = RSTV, m_stv = '0;

  function automatic bit st_bit_ok(int b);
    return b == 1 || b == 3 || b == 5 || b == 7 || b == 8 || b == 11 || b == 12 ||
           b == 13 || b == 14 || b == 17 || b == 18 || b == 19;
  endfunction

  function automatic bit sview_bit(int b);
    return b == 1 || b == 5 || b == 8 || b == 13 || b == 14 || b == 15 || b == 16 || b == 18;
  endfunction

  function automatic logic [63:0] st_apply(logic [63:0] cur, logic [63:0] v);
    logic [63:0] r = cur;
    int mode = int'(v[28:24]);
    for (int b = 0; b < 64; b++) if (st_bit_ok(b)) r[b] = v[b];
    if (mode == 0 || mode == 9 || mode == 10) r[28:24] = v[28:24];
    return r;
  endfunction

  function automatic logic sd_of(logic [63:0] s);
    return (s[14:13] == 2'b11) || (s[16:15] == 2'b11);
  endfunction

  function automatic logic [63:0] ref_read(logic [11:0] a, output bit ill);
    logic [63:0] r = '0;
    ill = 0;
    case (a)
      12'h300: begin r = m_st; r[63] = sd_of(m_st); end
      12'h100: begin
        for (int b = 0; b < 64; b++) if (sview_bit(b)) r[b] = m_st[b];
        r[63] = sd_of(m_st);
      end
      12'h344: r = m_ip;
      12'h144: r = m_ip & m_dl;
      12'h304: r = m_ie;
      12'h104: r = m_ie & m_dl;
      12'h303: r = m_dl;
      12'h305: r = m_mt;
      12'h105: r = m_stv;
      default: ill = 1;
    endcase
    return r;
  endfunction

  function automatic bit ref_write(logic [11:0] a, logic [63:0] v);
    logic [63:0] old = m_st, t;
    case (a)
      12'h300: m_st = st_apply(m_st, v);
      12'h100: begin
        t = m_st;
        for (int b = 0; b < 64; b++) if (sview_bit(b)) t[b] = v[b];
        m_st = st_apply(m_st, t);
      end
      12'h344: begin m_ip[1] = v[1]; m_ip[5] = v[5]; end
      12'h144: begin
        if (m_dl[1]) m_ip[1] = v[1];
        if (m_dl[5]) m_ip[5] = v[5];
      end
      12'h304: for (int b = 1; b <= 9; b += 2) m_ie[b] = v[b];
      12'h104: for (int b = 1; b <= 9; b += 2) if (m_dl[b]) m_ie[b] = v[b];
      12'h303: begin m_dl[1] = v[1]; m_dl[5] = v[5]; m_dl[9] = v[9]; end
      12'h305: m_mt = {v[63:2], 2'b00};
      12'h105: m_stv = {v[63:2], 2'b00};
      default: ;
    endcase
    return (old[28:24] != m_st[28:24]) || (old[12:11] != m_st[12:11]) ||
           (old[19:17] != m_st[19:17]);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at following negedge
  task automatic step(bit w, logic [11:0] wa, logic [63:0] wd,
                      bit r, logic [11:0] ra, string req);
    logic [63:0] exp_d;
    bit exp_ill, exp_fl;
    exp_d = r ? ref_read(ra, exp_ill) : 64'd0;
    if (!r) exp_ill = 0;
    exp_fl = w ? ref_write(wa, wd) : 1'b0;
    wr_en = w; wr_addr = wa; wr_data = wd;
    rd_en = r; rd_addr = ra;
    @(negedge clk);
    check(flush == exp_fl, {req, " flush"}, 64'(flush), 64'(exp_fl));
    if (r) begin
      check(illegal == exp_ill, {req, " illegal"}, 64'(illegal), 64'(exp_ill));
      check(rdata == exp_d, {req, " data"}, rdata, exp_d);
    end
  endtask

  task automatic rd(logic [11:0] a, string req);
    step(0, '0, '0, 1, a, req);
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] v, string req);
    step(1, a, v, 0, '0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset values
    rd(12'h300, "R11 mstatus");
    rd(12'h305, "R11 mtvec");
    rd(12'h304, "R11 mie");
    rd(12'h105, "R11 stvec");

    // R1 R2 R3 R9: all ones, VM 31 illegal, FS=3 sets summary
    wr(12'h300, '1, "R1 R9 mstatus all ones");
    rd(12'h300, "R1 R2 R3 mstatus read");
    // R2 legal and illegal modes
    wr(12'h300, 64'h0900_0000 | 64'h6000, "R2 R9 vm 39");
    rd(12'h300, "R2 vm 39 read");
    wr(12'h300, 64'h0800_0000 | 64'h6000, "R2 R9 vm 32 rejected");
    rd(12'h300, "R2 vm 32 read");
    wr(12'h300, 64'h0A00_0000, "R3 R9 vm 48 fs clear");
    rd(12'h300, "R3 summary clear");
    // R9 no flush on SIE-only change
    wr(12'h300, 64'h0A00_0002, "R9 sie only");
    // R1 XS not writable
    wr(12'h300, 64'h0A01_8002, "R1 xs write");
    rd(12'h300, "R1 xs locked");

    // R7 supervisor status view
    wr(12'h300, 64'h0, "R9 clear status");
    wr(12'h100, '1, "R7 R9 sstatus all ones");
    rd(12'h100, "R7 sstatus read");
    rd(12'h300, "R7 mstatus after sview");

    // R4 R5 masks
    wr(12'h344, '1, "R4 mip all ones");
    rd(12'h344, "R4 mip read");
    wr(12'h304, '1, "R5 mie all ones");
    rd(12'h304, "R5 mie read");
    wr(12'h303, '1, "R5 mideleg all ones");
    rd(12'h303, "R5 mideleg read");

    // R6 partial delegation
    wr(12'h303, 64'h2, "R6 deleg ssw only");
    wr(12'h144, 64'h0, "R6 sip clear");
    rd(12'h344, "R6 mip after sip");
    rd(12'h144, "R6 sip read");
    wr(12'h104, 64'h0, "R6 sie clear");
    rd(12'h304, "R6 mie after sie");
    rd(12'h104, "R6 sie read");
    wr(12'h303, 64'h220, "R6 deleg stm sex");
    wr(12'h104, 64'h2A2, "R6 sie set");
    rd(12'h304, "R6 mie after sie set");

    // R8 vector alignment
    wr(12'h305, 64'hDEAD_BEEF_0000_00FF, "R8 mtvec");
    rd(12'h305, "R8 mtvec read");
    wr(12'h105, 64'h0000_0000_1234_5677, "R8 stvec");
    rd(12'h105, "R8 stvec read");

    // R10 illegal addresses, same-cycle write, write to unknown address
    rd(12'h7FF, "R10 illegal 7ff");
    rd(12'h305, "R10 legal after illegal");
    rd(12'h340, "R10 illegal 340");
    wr(12'h7C0, '1, "R10 write unknown");
    rd(12'h303, "R10 deleg unchanged");
    step(1, 12'h305, 64'h4000, 1, 12'h305, "R10 read old on same-cycle write");
    rd(12'h305, "R10 read new");
    step(0, '0, '0, 0, '0, "R9 idle");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule